// File: doc/BRIEF.md
# Head-per-Track Disk/Drum Position Sequencer

This block tracks where a head-per-track storage unit currently is: a word position inside a sector, the sector inside a track, and the track. The sector and track are not kept as separate counters. They live inside a 16-bit command word, and the block rewrites that word in place. Each advance strobe moves the position forward by one word. When a sector ends, the sector and track fields of the command word are updated, and a one-cycle end-of-sector pulse is produced.

A mode input selects one of two geometries. In disk mode a track has 90 sectors and there are 128 tracks. In drum mode a track has 32 sectors and there are 1024 tracks. Every sector holds 64 words in both modes. The top bit of the command word marks the transfer direction, and the sequencer carries it through unchanged.

A controller loads a command word to start a transfer. It then pulses advance once per word moved, reads back the updated command word, and uses the end-of-sector pulse to pace per-sector work.

Top module: `track_sector_sequencer`

## Requirements
- R1: A synchronous active-high `rst` clears `cmd_word` to 0, `word_ptr` to 0 and `sector_end` to 0 on the next clock edge.
- R2: While `load` is high at a clock edge, `cmd_word` takes `cmd_in` and `word_ptr` becomes 0 at that edge. If `advance` is also high, `load` takes priority and no advance happens.
- R3: An `advance` without `load` raises `word_ptr` by one. From 63 it wraps to 0.
- R4: `cmd_word` does not change at an edge unless `load` is high, or `advance` is high while `word_ptr` is 63.
- R5: Bit 15 of `cmd_word` (1 = write, 0 = read) is never altered by the sequencer. Only a load changes it.
- R6: In disk mode (`drum_mode`=0) the track is bits 13:7 and the sector is bits 6:0. At a word wrap the sector increments. A result of 90 or more sets the sector to 0 and increments the track, and track 127 wraps to 0. The rewritten word has bit 14 cleared.
- R7: In drum mode (`drum_mode`=1) the track is bits 14:5 and the sector is bits 4:0. At a word wrap the sector increments. Passing sector 31 sets it to 0 and increments the track, and track 1023 wraps to 0.
- R8: `sector_end` is high for exactly the one cycle following the edge at which an advance wrapped `word_ptr` from 63 to 0. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load strobe for `cmd_in` |
| cmd_in | input | 16 | Command word to load |
| drum_mode | input | 1 | 1 = drum geometry, 0 = disk geometry |
| advance | input | 1 | Advance by one word |
| cmd_word | output | 16 | Current packed command word |
| word_ptr | output | 6 | Word position inside the sector |
| sector_end | output | 1 | One-cycle pulse after a sector finishes |

## Verification
The embedded assertions check the local rules on every cycle:
- the pointer step and its wrap,
- load priority,
- the stability of the command word between sector wraps,
- the preserved direction bit,
- the alignment of the end-of-sector pulse with a zero pointer.

The arithmetic of the field rewrite is covered only by the bench's reference model and its scenarios. That includes the sector limits of 90 and 32, the track wraps at 127 and 1023, clearing bit 14 in disk mode, and the handling of an out-of-range loaded sector. These scenarios place loads right at those boundaries and compare every cycle.

// File: rtl/track_sector_sequencer.sv
module track_sector_sequencer #(
  parameter int WORDS_PER_SECTOR = 64,
  parameter int DISK_SECTORS     = 90,
  parameter int DRUM_SECTORS     = 32,
  parameter int DISK_TRACKS      = 128,
  parameter int DRUM_TRACKS      = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [15:0] cmd_in,
  input  logic        drum_mode,
  input  logic        advance,
  output logic [15:0] cmd_word,
  output logic [5:0]  word_ptr,
  output logic        sector_end
);
  localparam int PTR_W     = $clog2(WORDS_PER_SECTOR);
  localparam int LAST_WORD = WORDS_PER_SECTOR - 1;

  logic [15:0]      cmd_q;
  logic [PTR_W-1:0] ptr_q;
  logic             end_q;

  logic [9:0]  trk_cur, trk_next;
  logic [6:0]  sec_cur, sec_next;
  logic [31:0] sec_lim, trk_lim;
  logic        at_last, sec_wrap, trk_wrap;
  logic [15:0] repacked;

  assign trk_cur  = drum_mode ? cmd_q[14:5] : {3'b000, cmd_q[13:7]};
  assign sec_cur  = drum_mode ? {2'b00, cmd_q[4:0]} : cmd_q[6:0];
  assign sec_lim  = drum_mode ? DRUM_SECTORS : DISK_SECTORS;
  assign trk_lim  = drum_mode ? DRUM_TRACKS : DISK_TRACKS;
  assign at_last  = (ptr_q == PTR_W'(LAST_WORD));
  assign sec_wrap = ({25'd0, sec_cur} + 32'd1) >= sec_lim;
  assign trk_wrap = ({22'd0, trk_cur} + 32'd1) >= trk_lim;
  assign sec_next = sec_wrap ? 7'd0 : sec_cur + 7'd1;
  assign trk_next = !sec_wrap ? trk_cur : (trk_wrap ? 10'd0 : trk_cur + 10'd1);
  assign repacked = drum_mode ? {cmd_q[15], trk_next, sec_next[4:0]}
                              : {cmd_q[15], 1'b0, trk_next[6:0], sec_next};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      ptr_q <= '0;
      end_q <= 1'b0;
    end else if (load) begin
      cmd_q <= cmd_in;
      ptr_q <= '0;
      end_q <= 1'b0;
    end else if (advance) begin
      ptr_q <= at_last ? '0 : ptr_q + PTR_W'(1);
      end_q <= at_last;
      if (at_last) cmd_q <= repacked;
    end else begin
      end_q <= 1'b0;
    end
  end

  assign cmd_word   = cmd_q;
  assign word_ptr   = ptr_q;
  assign sector_end = end_q;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (cmd_word == 16'd0 && word_ptr == 6'd0 && !sector_end));

  assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (word_ptr == 6'd0 && cmd_word == $past(cmd_in) && !sector_end));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && word_ptr != 6'd63) |=> word_ptr == $past(word_ptr) + 6'd1);

  assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && word_ptr == 6'd63) |=> word_ptr == 6'd0);

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !(advance && word_ptr == 6'd63)) |=> $stable(cmd_word));

  assert_dir_bit_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> cmd_word[15] == $past(cmd_word[15]));

  assert_end_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    sector_end |-> (word_ptr == 6'd0 && !$past(load) && $past(advance)));

  assert_end_single_R8: assert property (@(posedge clk) disable iff (rst)
    sector_end |=> !sector_end || (word_ptr == 6'd0));
endmodule

// File: tb/track_sector_sequencer_tb.sv
module track_sector_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [15:0] cmd_in = '0;
  logic        drum_mode = 1'b0;
  logic        advance = 1'b0;
  logic [15:0] cmd_word;
  logic [5:0]  word_ptr;
  logic        sector_end;

  int checks = 0;
  int failures = 0;
  int m_cmd = 0, m_ptr = 0, m_end = 0;

  always #5 clk = ~clk;

  track_sector_sequencer u_dut (
    .clk(clk), .rst(rst), .load(load), .cmd_in(cmd_in), .drum_mode(drum_mode),
    .advance(advance), .cmd_word(cmd_word), .word_ptr(word_ptr), .sector_end(sector_end)
  );

  task automatic model_edge();
    int trk, sec, nsec, ntrk, scale;
    if (rst) begin
      m_cmd = 0; m_ptr = 0; m_end = 0;
    end else if (load) begin
      m_cmd = int'(cmd_in); m_ptr = 0; m_end = 0;
    end else if (advance) begin
      if (m_ptr == 63) begin
        m_ptr = 0; m_end = 1;
        scale = drum_mode ? 32 : 128;
        nsec  = drum_mode ? 32 : 90;
        ntrk  = drum_mode ? 1024 : 128;
        sec = m_cmd % scale;
        trk = (m_cmd / scale) % ntrk;
        sec = sec + 1;
        if (sec >= nsec) begin
          sec = 0; trk = trk + 1;
          if (trk >= ntrk) trk = 0;
        end
        m_cmd = (m_cmd & 32768) + trk * scale + sec;
      end else begin
        m_ptr = m_ptr + 1; m_end = 0;
      end
    end else begin
      m_end = 0;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (int'(cmd_word) != m_cmd || int'(word_ptr) != m_ptr || int'(sector_end) != m_end) begin
      failures++;
      $display("FAIL %s: act cmd=%h ptr=%0d end=%0d exp cmd=%h ptr=%0d end=%0d",
               tag, cmd_word, word_ptr, sector_end, m_cmd[15:0], m_ptr, m_end);
    end
  endtask

  task automatic step(input logic l, input logic [15:0] c, input logic m,
                      input logic a, input string tag);
    load = l; cmd_in = c; drum_mode = m; advance = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input int n, input logic m, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0, m, 1'b1, tag);
  endtask

  task automatic expect_cmd(input logic [15:0] exp, input string tag);
    checks++;
    if (cmd_word !== exp) begin
      failures++;
      $display("FAIL %s: act cmd=%h exp cmd=%h", tag, cmd_word, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    step(1'b0, 16'h0, 1'b0, 1'b0, "R1");
    rst = 1'b0;
    step(1'b0, 16'h0, 1'b0, 1'b1, "R3");
    rst = 1'b1;
    step(1'b0, 16'h0, 1'b0, 1'b0, "R1");
    rst = 1'b0;

    // disk: track 5, sector 88, read
    step(1'b1, (16'd5 << 7) | 16'd88, 1'b0, 1'b0, "R2");
    run(64, 1'b0, "R6");
    expect_cmd((16'd5 << 7) | 16'd89, "R6");
    step(1'b0, 16'h0, 1'b0, 1'b0, "R8");
    run(64, 1'b0, "R6");
    expect_cmd(16'd6 << 7, "R6");
    run(10, 1'b0, "R4");
    step(1'b0, 16'h0, 1'b0, 1'b0, "R4");

    // disk last track/sector with write bit and stray bit 14
    step(1'b1, 16'hC000 | (16'd127 << 7) | 16'd89, 1'b0, 1'b0, "R2");
    run(64, 1'b0, "R5");
    expect_cmd(16'h8000, "R6");

    // disk out-of-range sector 100
    step(1'b1, (16'd3 << 7) | 16'd100, 1'b0, 1'b0, "R2");
    run(64, 1'b0, "R6");
    expect_cmd(16'd4 << 7, "R6");

    // drum last track/sector, write
    step(1'b1, 16'h8000 | (16'd1023 << 5) | 16'd31, 1'b1, 1'b0, "R2");
    run(64, 1'b1, "R7");
    expect_cmd(16'h8000, "R7");

    // drum mid-track, read
    step(1'b1, (16'd3 << 5) | 16'd10, 1'b1, 1'b0, "R2");
    run(30, 1'b1, "R3");
    step(1'b1, (16'd700 << 5) | 16'd30, 1'b1, 1'b1, "R2");
    run(128, 1'b1, "R7");
    expect_cmd(16'd701 << 5, "R7");

    // load in the very cycle the pointer would wrap
    run(63, 1'b1, "R3");
    step(1'b1, 16'h1234, 1'b1, 1'b1, "R2");
    expect_cmd(16'h1234, "R2");
    run(64, 1'b1, "R8");
    step(1'b0, 16'h0, 1'b1, 1'b0, "R8");
    run(200, 1'b0, "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: act running exp finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule